// File: doc/BRIEF.md
# Burst Packet Receive Filter

This block sits behind a clock-recovery stage and watches its recovered bit stream. It hunts for a run of alternating bits, then checks the next group of bits against a configured station address. When the address matches, it captures a configured number of payload bits and, if enabled, checks a trailing CRC that covers the address and the payload. A packet that passes every check is kept in an internal buffer and announced on `pay_valid`. Any other packet is dropped without a trace.

The host drains the stored payload one bit at a time at its own pace, using a valid/ready handshake. The first payload bit received comes out first. The incoming bit stream has no back-pressure, because bits arrive at the radio's rate. For that reason `bit_valid` is a plain strobe with no ready. On the output side, `pay_valid` doubles as the data-ready flag. Once asserted it stays high and `pay_data` stays steady until the host accepts the bit with `pay_ready`. After the last bit is accepted, `pay_valid` falls and the filter can take the next packet. For simultaneous reception on two frequency channels, use one instance per channel.

Top module: `rxf_packet_filter`

## Requirements
- R1: While `rx_enable` is high and nothing is awaiting readout, the filter hunts on each `bit_valid` for 8 consecutive alternating bits (either 01010101 or 10101010). The address compare starts on the very next strobed bit.
- R2: The address width is `cfg_addr_bits`, clamped to the range 8 to 40. The filter compares that many bits, most significant first, with `cfg_addr[width-1:0]`. Bits of `cfg_addr` above the width have no effect. The first mismatching bit discards the packet and resumes hunting.
- R3: After the address, the filter captures `cfg_payload_bits` payload bits (1 to 255, where 0 is taken as 1). Widths, address and CRC settings are latched when the preamble completes.
- R4: When `cfg_crc_on` is 1, a CRC follows the payload, sent most significant bit first. It covers the address and payload bits in wire order, with no final inversion:
  - `cfg_crc_wide`=1 selects 16 bits, polynomial 0x1021, preset 0xFFFF.
  - `cfg_crc_wide`=0 selects 8 bits, polynomial 0x07, preset 0xFF.
  A wrong CRC discards the packet. When `cfg_crc_on` is 0, no CRC bits are expected.
- R5: On acceptance, `pay_valid` rises in the cycle after the edge that takes the packet's final bit. A discarded packet leaves `pay_valid` low.
- R6: `pay_data` presents the payload in reception order, first bit first. Each cycle with `pay_valid` and `pay_ready` both high advances one bit. With `pay_ready` low, `pay_valid` and `pay_data` hold.
- R7: `pay_valid` falls after the handshake of the last payload bit. A preamble that completes in that same cycle starts a new packet.
- R8: While a payload awaits readout, new packets are dropped and the stored payload is not altered.
- R9: With `rx_enable` low, strobed bits are ignored and any packet in progress is abandoned. Readout of a stored payload is unaffected.
- R10: After reset, `pay_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_enable | input | 1 | Receive enable; low abandons and ignores input bits |
| bit_valid | input | 1 | Strobe: `bit_data` carries a recovered bit this cycle |
| bit_data | input | 1 | Recovered serial bit |
| cfg_addr | input | 40 | Station address, right-aligned |
| cfg_addr_bits | input | 6 | Address width in bits |
| cfg_payload_bits | input | 8 | Payload length in bits |
| cfg_crc_on | input | 1 | CRC present and checked |
| cfg_crc_wide | input | 1 | 1: 16-bit CRC, 0: 8-bit CRC |
| pay_valid | output | 1 | Payload bit available (data ready) |
| pay_data | output | 1 | Current payload bit |
| pay_ready | input | 1 | Host accepts the current bit |

## Verification
The critical overlap is the host's handshake on the final stored bit landing in the same cycle that a new preamble completes. The bench reads all but one bit of a stored payload. It then strobes the eighth alternating bit of a second packet in the same cycle that it raises `pay_ready`. The result is judged at the ports. `pay_valid` must drop for exactly that cycle. The second packet must then be accepted and read back intact, which shows it was neither dropped as "busy" nor mixed into the first payload. A second overlap occurs when a whole packet arrives while a payload is pending. That case is judged by reading back the older payload unchanged.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    ST_HUNT,
    ST_ADDR,
    ST_PAY,
    ST_CHK
  } rxf_state_e;
endpackage

// File: rtl/rxf_preamble_det.sv
module rxf_preamble_det #(
  parameter int unsigned PRE_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic take,
  input  logic bit_i,
  output logic hit_o
);
  localparam int unsigned RUN_W = $clog2(PRE_LEN + 1);

  logic [RUN_W-1:0] run_q, run_nxt;
  logic             last_q;

  // length of the alternating run that ends with bit_i
  always_comb begin
    if (run_q == '0)
      run_nxt = RUN_W'(1);
    else if (bit_i != last_q)
      run_nxt = (run_q == RUN_W'(PRE_LEN)) ? run_q : run_q + RUN_W'(1);
    else
      run_nxt = RUN_W'(1);
  end

  assign hit_o = take && (run_nxt == RUN_W'(PRE_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      last_q <= 1'b0;
    end else if (clear) begin
      run_q  <= '0;
    end else if (take) begin
      run_q  <= run_nxt;
      last_q <= bit_i;
    end
  end
endmodule

// File: rtl/rxf_crc_lane.sv
module rxf_crc_lane #(
  parameter int unsigned    W      = 16,
  parameter logic [W-1:0]   POLY   = '1,
  parameter logic [W-1:0]   PRESET = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic shift,
  input  logic bit_i,
  output logic zero_o
);
  logic [W-1:0] st_q, st_nxt;

  always_comb begin
    st_nxt = {st_q[W-2:0], 1'b0};
    if (st_q[W-1] ^ bit_i) st_nxt = st_nxt ^ POLY;
  end

  // remainder after feeding the received check bits is zero on a match
  assign zero_o = (st_nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= PRESET;
    else if (init)  st_q <= PRESET;
    else if (shift) st_q <= st_nxt;
  end
endmodule

// File: rtl/rxf_payload_buf.sv
module rxf_payload_buf #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned DEPTH = (1 << IDX_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_shift,
  input  logic             cap_bit,
  input  logic             commit,
  input  logic [IDX_W-1:0] commit_len,
  input  logic             pay_ready,
  output logic             pay_valid,
  output logic             pay_data,
  output logic             busy_next
);
  logic [DEPTH-1:0] store_q;
  logic [IDX_W-1:0] rd_q;
  logic             pop;

  assign pop       = pay_valid && pay_ready;
  assign pay_data  = store_q[rd_q];
  assign busy_next = pay_valid && !(pay_ready && (rd_q == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (cap_shift) begin
      store_q <= {store_q[DEPTH-2:0], cap_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay_valid <= 1'b0;
      rd_q      <= '0;
    end else if (commit) begin
      pay_valid <= 1'b1;
      rd_q      <= commit_len - IDX_W'(1);
    end else if (pop) begin
      if (rd_q == '0) pay_valid <= 1'b0;
      else            rd_q      <= rd_q - IDX_W'(1);
    end
  end
endmodule

// File: rtl/rxf_packet_filter.sv
module rxf_packet_filter
  import rxf_pkg::*;
#(
  parameter int unsigned ADDR_MAX  = 40,
  parameter int unsigned ADDR_MIN  = 8,
  parameter int unsigned PW_W      = 8,
  parameter int unsigned PRE_LEN   = 8,
  parameter logic [15:0] CRC16_POLY = 16'h1021,
  parameter logic [15:0] CRC16_INIT = 16'hFFFF,
  parameter logic [7:0]  CRC8_POLY  = 8'h07,
  parameter logic [7:0]  CRC8_INIT  = 8'hFF
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rx_enable,
  input  logic                            bit_valid,
  input  logic                            bit_data,
  input  logic [ADDR_MAX-1:0]             cfg_addr,
  input  logic [$clog2(ADDR_MAX+1)-1:0]   cfg_addr_bits,
  input  logic [PW_W-1:0]                 cfg_payload_bits,
  input  logic                            cfg_crc_on,
  input  logic                            cfg_crc_wide,
  output logic                            pay_valid,
  output logic                            pay_data,
  input  logic                            pay_ready
);
  localparam int unsigned AW_W  = $clog2(ADDR_MAX + 1);
  localparam int unsigned CNT_W = PW_W;

  rxf_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [AW_W-1:0]   aw_q, aw_eff, exp_idx;
  logic [PW_W-1:0]   pw_q, pw_eff;
  logic              crc_on_q, crc_wide_q;

  logic take, hit, start, busy_next, det_clear;
  logic addr_ok, crc_last, crc_zero, z16, z8;
  logic cap_shift, commit, crc_shift;

  assign take = bit_valid && rx_enable;

  always_comb begin
    if (cfg_addr_bits > AW_W'(ADDR_MAX))      aw_eff = AW_W'(ADDR_MAX);
    else if (cfg_addr_bits < AW_W'(ADDR_MIN)) aw_eff = AW_W'(ADDR_MIN);
    else                                      aw_eff = cfg_addr_bits;
    pw_eff = (cfg_payload_bits == '0) ? PW_W'(1) : cfg_payload_bits;
  end

  assign det_clear = (st_q != ST_HUNT) || !rx_enable || start;

  rxf_preamble_det #(.PRE_LEN(PRE_LEN)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (det_clear),
    .take  (take && (st_q == ST_HUNT)),
    .bit_i (bit_data),
    .hit_o (hit)
  );

  assign start = hit && !busy_next;

  assign exp_idx  = AW_W'(aw_q - AW_W'(1) - cnt_q[AW_W-1:0]);
  assign addr_ok  = (bit_data == cfg_addr[exp_idx]);
  assign crc_last = crc_wide_q ? (cnt_q == CNT_W'(15)) : (cnt_q == CNT_W'(7));
  assign crc_zero = crc_wide_q ? z16 : z8;

  assign crc_shift = take && (st_q != ST_HUNT);
  assign cap_shift = take && (st_q == ST_PAY);
  assign commit    = take && (((st_q == ST_PAY) && (cnt_q == pw_q - PW_W'(1)) && !crc_on_q) ||
                              ((st_q == ST_CHK) && crc_last && crc_zero));

  rxf_crc_lane #(.W(16), .POLY(CRC16_POLY), .PRESET(CRC16_INIT)) u_crc16 (
    .clk(clk), .rst_n(rst_n), .init(start), .shift(crc_shift), .bit_i(bit_data), .zero_o(z16)
  );

  rxf_crc_lane #(.W(8), .POLY(CRC8_POLY), .PRESET(CRC8_INIT)) u_crc8 (
    .clk(clk), .rst_n(rst_n), .init(start), .shift(crc_shift), .bit_i(bit_data), .zero_o(z8)
  );

  rxf_payload_buf #(.IDX_W(PW_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_shift  (cap_shift),
    .cap_bit    (bit_data),
    .commit     (commit),
    .commit_len (pw_q),
    .pay_ready  (pay_ready),
    .pay_valid  (pay_valid),
    .pay_data   (pay_data),
    .busy_next  (busy_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_HUNT;
      cnt_q      <= '0;
      aw_q       <= AW_W'(ADDR_MIN);
      pw_q       <= PW_W'(1);
      crc_on_q   <= 1'b0;
      crc_wide_q <= 1'b0;
    end else if (!rx_enable) begin
      st_q  <= ST_HUNT;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_HUNT: if (start) begin
          st_q       <= ST_ADDR;
          cnt_q      <= '0;
          aw_q       <= aw_eff;
          pw_q       <= pw_eff;
          crc_on_q   <= cfg_crc_on;
          crc_wide_q <= cfg_crc_wide;
        end
        ST_ADDR: if (take) begin
          if (!addr_ok) begin
            st_q  <= ST_HUNT;
            cnt_q <= '0;
          end else if (cnt_q == CNT_W'(aw_q - AW_W'(1))) begin
            st_q  <= ST_PAY;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_PAY: if (take) begin
          if (cnt_q == pw_q - PW_W'(1)) begin
            st_q  <= crc_on_q ? ST_CHK : ST_HUNT;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_CHK: if (take) begin
          if (crc_last) begin
            st_q  <= ST_HUNT;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: st_q <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/rxf_packet_filter_chk.sv
module rxf_packet_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_enable,
  input logic bit_valid,
  input logic pay_valid,
  input logic pay_ready,
  input logic pay_data,
  input logic commit,
  input logic cap_shift
);
  assert_hold_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_valid && !pay_ready) |=> pay_valid);

  assert_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_valid && !pay_ready) |=> $stable(pay_data));

  assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_valid && !pay_ready) |-> !cap_shift);

  assert_commit_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (!pay_valid || pay_ready));

  assert_rise_on_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pay_valid) |-> $past(bit_valid && rx_enable));

  assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |-> (!commit && !cap_shift));
endmodule

bind rxf_packet_filter rxf_packet_filter_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_enable (rx_enable),
  .bit_valid (bit_valid),
  .pay_valid (pay_valid),
  .pay_ready (pay_ready),
  .pay_data  (pay_data),
  .commit    (commit),
  .cap_shift (cap_shift)
);

// File: tb/rxf_packet_filter_tb_top.sv
module rxf_packet_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 8;

  // aw[122:117] pw[116:109] crc_on[108] wide[107] addr[106:67] pay[66:3] corrupt[2:1] exp[0]
  localparam logic [122:0] VECS [NVEC] = '{
    {6'd8,  8'd8,  1'b1, 1'b1, 40'hA5,         64'h3C,                2'd0, 1'b1},
    {6'd16, 8'd12, 1'b1, 1'b0, 40'h1234,       64'hABC,               2'd0, 1'b1},
    {6'd40, 8'd32, 1'b1, 1'b1, 40'hC3A5F0E1D2, 64'hDEADBEEF,          2'd0, 1'b1},
    {6'd24, 8'd16, 1'b0, 1'b0, 40'h5A3C96,     64'h8001,              2'd0, 1'b1},
    {6'd16, 8'd8,  1'b1, 1'b1, 40'hBEEF,       64'h55,                2'd1, 1'b0},
    {6'd16, 8'd20, 1'b1, 1'b0, 40'h0F3C,       64'hFFFFF,             2'd2, 1'b0},
    {6'd32, 8'd64, 1'b1, 1'b1, 40'h89ABCDEF,   64'h0123456789ABCDEF,  2'd0, 1'b1},
    {6'd8,  8'd1,  1'b0, 1'b0, 40'h81,         64'h1,                 2'd0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_enable = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b0;
  logic [39:0] cfg_addr = '0;
  logic [5:0]  cfg_addr_bits = 6'd8;
  logic [7:0]  cfg_payload_bits = 8'd8;
  logic cfg_crc_on = 1'b0;
  logic cfg_crc_wide = 1'b0;
  logic pay_valid, pay_data;
  logic pay_ready = 1'b0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  logic pk_bits [0:399];
  int   pk_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxf_packet_filter dut_i (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable),
    .bit_valid(bit_valid), .bit_data(bit_data),
    .cfg_addr(cfg_addr), .cfg_addr_bits(cfg_addr_bits),
    .cfg_payload_bits(cfg_payload_bits), .cfg_crc_on(cfg_crc_on),
    .cfg_crc_wide(cfg_crc_wide),
    .pay_valid(pay_valid), .pay_data(pay_data), .pay_ready(pay_ready)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles, expected < %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] cstep(input logic [15:0] c, input logic b, input logic wide);
    logic [15:0] r;
    if (wide) begin
      r = {c[14:0], 1'b0};
      if (c[15] ^ b) r = r ^ 16'h1021;
    end else begin
      r = {8'h00, c[6:0], 1'b0};
      if (c[7] ^ b) r = r ^ 16'h0007;
    end
    return r;
  endfunction

  task automatic build_pkt(input int aw, input int pw, input logic con, input logic wide,
                           input logic [39:0] addr, input logic [255:0] pay, input int corrupt);
    logic [15:0] c;
    logic a0;
    int n;
    c  = wide ? 16'hFFFF : 16'h00FF;
    a0 = addr[aw-1];
    n  = 0;
    for (int i = 0; i < 2; i++) begin pk_bits[n] = a0; n++; end
    for (int i = 0; i < 8; i++) begin pk_bits[n] = a0 ^ i[0]; n++; end
    for (int i = 0; i < aw; i++) begin
      c = cstep(c, addr[aw-1-i], wide);
      pk_bits[n] = addr[aw-1-i] ^ ((corrupt == 1) && (i == 3));
      n++;
    end
    for (int i = 0; i < pw; i++) begin
      c = cstep(c, pay[pw-1-i], wide);
      pk_bits[n] = pay[pw-1-i];
      n++;
    end
    if (con) begin
      int len;
      len = wide ? 16 : 8;
      for (int i = 0; i < len; i++) begin
        pk_bits[n] = c[len-1-i] ^ ((corrupt == 2) && (i == len-1));
        n++;
      end
    end
    pk_len = n;
  endtask

  task automatic sbit(input logic b);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_data  = b;
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic send_range(input int from, input int upto);
    for (int i = from; i < upto; i++) sbit(pk_bits[i]);
  endtask

  task automatic set_cfg(input int aw, input int pw, input logic con, input logic wide, input logic [39:0] addr);
    logic [39:0] mask;
    mask = (40'h1 << aw) - 40'h1;
    cfg_addr_bits    = 6'(aw);
    cfg_payload_bits = 8'(pw);
    cfg_crc_on       = con;
    cfg_crc_wide     = wide;
    cfg_addr         = (addr & mask) | (~mask & 40'hA5_5A69_C3F0); // R2: bits above width are noise
  endtask

  // reads bits pw-1 .. stop_at; checks order (R6) and optional stall hold
  task automatic read_bits(input int pw, input logic [255:0] exp, input int stop_at, input bit stall);
    for (int i = pw - 1; i >= stop_at; i--) begin
      chk(pay_valid === 1'b1, "R6 valid during readout", 64'(pay_valid), 64'd1);
      chk(pay_data === exp[i], "R6 payload bit order", 64'(pay_data), 64'(exp[i]));
      if (stall) begin
        @(negedge clk);
        chk(pay_valid === 1'b1 && pay_data === exp[i], "R6 hold while not ready",
            64'({pay_valid, pay_data}), 64'({1'b1, exp[i]}));
      end
      pay_ready = 1'b1;
      @(negedge clk);
      pay_ready = 1'b0;
    end
  endtask

  initial begin
    logic [255:0] pay_a, pay_b;
    // reset
    repeat (3) @(negedge clk);
    chk(pay_valid === 1'b0, "R10 reset pay_valid", 64'(pay_valid), 64'd0);
    rst_n = 1'b1;
    rx_enable = 1'b1;
    @(negedge clk);
    chk(pay_valid === 1'b0, "R10 idle after reset", 64'(pay_valid), 64'd0);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [122:0] w;
      int aw, pw, cor;
      logic exp_ok;
      w = VECS[v];
      aw = int'(w[122:117]); pw = int'(w[116:109]); cor = int'(w[2:1]); exp_ok = w[0];
      set_cfg(aw, pw, w[108], w[107], w[106:67]);
      pay_a = 256'(w[66:3]);
      build_pkt(aw, pw, w[108], w[107], w[106:67], pay_a, cor);
      send_range(0, pk_len);
      if (cor == 1)
        chk(pay_valid === 1'b0, "R2 address mismatch discarded", 64'(pay_valid), 64'd0);
      else if (cor == 2)
        chk(pay_valid === 1'b0, "R4 CRC mismatch discarded", 64'(pay_valid), 64'd0);
      else
        chk(pay_valid === exp_ok, "R1 R5 accept after final bit", 64'(pay_valid), 64'(exp_ok));
      if (exp_ok) begin
        read_bits(pw, pay_a, 0, v[0]);
        chk(pay_valid === 1'b0, "R7 valid falls after last bit", 64'(pay_valid), 64'd0);
      end
    end

    // R3: longest payload, 16-bit CRC, widest address
    pay_a = {4{64'hF0E1_D2C3_B4A5_9687}};
    set_cfg(40, 255, 1'b1, 1'b1, 40'h96_3C5A_E187);
    build_pkt(40, 255, 1'b1, 1'b1, 40'h96_3C5A_E187, pay_a, 0);
    send_range(0, pk_len);
    chk(pay_valid === 1'b1, "R3 255-bit payload accepted", 64'(pay_valid), 64'd1);
    read_bits(255, pay_a, 0, 1'b0);
    chk(pay_valid === 1'b0, "R3 255-bit readout complete", 64'(pay_valid), 64'd0);

    // R8: packet while pending is dropped, stored payload intact
    pay_a = 256'h9C;
    set_cfg(16, 8, 1'b1, 1'b0, 40'h3A6C);
    build_pkt(16, 8, 1'b1, 1'b0, 40'h3A6C, pay_a, 0);
    send_range(0, pk_len);
    chk(pay_valid === 1'b1, "R8 first packet stored", 64'(pay_valid), 64'd1);
    build_pkt(16, 8, 1'b1, 1'b0, 40'h3A6C, 256'h63, 0);
    send_range(0, pk_len);
    chk(pay_valid === 1'b1, "R8 still pending", 64'(pay_valid), 64'd1);
    read_bits(8, pay_a, 0, 1'b0);
    chk(pay_valid === 1'b0, "R8 dropped packet not queued", 64'(pay_valid), 64'd0);

    // R7: preamble completes in the same cycle as the final handshake
    pay_a = 256'hB;
    set_cfg(8, 4, 1'b1, 1'b0, 40'h6D);
    build_pkt(8, 4, 1'b1, 1'b0, 40'h6D, pay_a, 0);
    send_range(0, pk_len);
    read_bits(4, pay_a, 1, 1'b0);
    chk(pay_data === pay_a[0], "R7 last bit before overlap", 64'(pay_data), 64'(pay_a[0]));
    pay_b = 256'hC6;
    set_cfg(8, 8, 1'b1, 1'b0, 40'h6D);
    build_pkt(8, 8, 1'b1, 1'b0, 40'h6D, pay_b, 0);
    send_range(0, 9);
    @(negedge clk);
    bit_valid = 1'b1; bit_data = pk_bits[9]; pay_ready = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0; pay_ready = 1'b0;
    chk(pay_valid === 1'b0, "R7 valid drops at overlap", 64'(pay_valid), 64'd0);
    send_range(10, pk_len);
    chk(pay_valid === 1'b1, "R7 overlapping preamble honoured", 64'(pay_valid), 64'd1);
    read_bits(8, pay_b, 0, 1'b0);

    // R9: enable low mid-packet abandons it
    set_cfg(16, 16, 1'b1, 1'b1, 40'hF00F);
    build_pkt(16, 16, 1'b1, 1'b1, 40'hF00F, 256'h0, 0);
    send_range(0, 20);
    rx_enable = 1'b0;
    send_range(20, 24);
    rx_enable = 1'b1;
    send_range(24, pk_len);
    chk(pay_valid === 1'b0, "R9 interrupted packet discarded", 64'(pay_valid), 64'd0);
    rx_enable = 1'b0;
    send_range(0, pk_len);
    chk(pay_valid === 1'b0, "R9 bits ignored while disabled", 64'(pay_valid), 64'd0);
    rx_enable = 1'b1;
    pay_a = 256'h5AF3;
    build_pkt(16, 16, 1'b1, 1'b1, 40'hF00F, pay_a, 0);
    send_range(0, pk_len);
    chk(pay_valid === 1'b1, "R9 accepted when enabled", 64'(pay_valid), 64'd1);
    rx_enable = 1'b0;
    read_bits(16, pay_a, 0, 1'b1);
    chk(pay_valid === 1'b0, "R9 readout while disabled", 64'(pay_valid), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule